// File: doc/BRIEF.md
# Byte-Fed Inner-Product Parity Engine

This block computes the binary inner product of a 512-bit secret and a 512-bit public challenge: every bit pair is ANDed, and the parity of the 512 products is returned as one bit. Both operands arrive over byte-wide serial inputs, one key byte and one challenge byte per beat. They collect in two shift-register deserializers. Once a full set is present, an active-low gate strobe moves both operands into the operand registers of the compute engine.

The compute engine works on one 64-bit group per clock. Each group is ANDed and reduced by a six-level parallel XOR tree. The eight group parities are folded one after another into an accumulator, so the result appears eight cycles after the transfer. The deserializers are free again as soon as the transfer happens, so the next query can be collected while the current one is still being folded.

A collector state machine has two states, `COL_GATHER` and `COL_FULL`. It goes from `COL_GATHER` to `COL_FULL` on the 64th beat and from `COL_FULL` back to `COL_GATHER` on a transfer. The engine state machine has two states, `ENG_IDLE` and `ENG_FOLD`. It goes from `ENG_IDLE` to `ENG_FOLD` on a transfer and from `ENG_FOLD` back to `ENG_IDLE` after the eighth fold step. Bytes are taken most-significant first, so the last byte of a set lands in bits 7:0 of each operand.

Top module: `ipar_engine`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both deserializers, the operand registers, the beat count, `parity` and `valid`. A gate strobe after reset, with no new beats, produces no result.
- R2: A beat is a rising edge at which `stream_en` is high. It shifts in one key byte and one challenge byte. A set is complete after 64 beats. A gate strobe seen before the 64th beat is ignored, and collection continues from the current count.
- R3: Beats that arrive after a set is complete and before its transfer are ignored. The set that was gathered stays intact.
- R4: When `gate_n` is low at a rising edge while a complete set is held, both operands are transferred to the engine and collection restarts empty.
- R5: The result bit equals the XOR over all 512 bit positions i of key[i] AND challenge[i].
- R6: `valid` is high for exactly one cycle. It rises after the 8th rising edge following the transfer edge.
- R7: `parity` keeps its value in every cycle in which `valid` is low.
- R8: Collection of the next set may overlap with the fold of the current one. Results come out in the order of their transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stream_en | input | 1 | Beat qualifier for the two byte inputs |
| key_byte | input | 8 | Secret operand byte, most-significant byte first |
| chal_byte | input | 8 | Challenge operand byte, most-significant byte first |
| gate_n | input | 1 | Active-low transfer strobe |
| parity | output | 1 | Inner-product parity of the last completed query |
| valid | output | 1 | One-cycle pulse marking a new parity |

## Verification
The assertions check on every cycle the timing rules: `valid` lasts one cycle and only ends a fold, `parity` holds between pulses, the beat count never passes 64, a transfer empties the collector, and a full set is frozen against extra beats. Only the bench scenarios can show that the parity value is correct for each operand pattern. The same goes for the cases where a gate strobe is ignored: after a short fill, after a mid-fill reset, or with junk beats after a full set. Only the bench can also show that overlapping queries come back in order and at the exact cycle.

// File: rtl/ipar_pkg.sv
package ipar_pkg;

    typedef enum logic [0:0] {
        COL_GATHER = 1'b0,
        COL_FULL   = 1'b1
    } col_state_e;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_FOLD = 1'b1
    } eng_state_e;

endpackage

// File: rtl/ipar_deser.sv
module ipar_deser #(
    parameter int W    = 512,
    parameter int LANE = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift,
    input  logic [LANE-1:0] din,
    output logic [W-1:0]    q
);

    // Newest byte enters at the bottom; the first byte ends up on top.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift) begin
            q <= {q[W-LANE-1:0], din};
        end
    end

endmodule

// File: rtl/ipar_xor_tree.sv
module ipar_xor_tree #(
    parameter int N = 64
) (
    input  logic [N-1:0] bits,
    output logic         par
);

    localparam int LV = $clog2(N);

    genvar l, i;
    generate
        for (l = 0; l < LV; l++) begin : g_lv
            logic [(N >> (l + 1))-1:0] v;
            for (i = 0; i < (N >> (l + 1)); i++) begin : g_node
                if (l == 0) begin : g_leaf
                    assign v[i] = bits[2*i] ^ bits[2*i+1];
                end else begin : g_inner
                    assign v[i] = g_lv[l-1].v[2*i] ^ g_lv[l-1].v[2*i+1];
                end
            end
        end
    endgenerate

    assign par = g_lv[LV-1].v[0];

endmodule

// File: rtl/ipar_fold.sv
module ipar_fold
    import ipar_pkg::*;
#(
    parameter int OPW = 512,
    parameter int PAR = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] key_in,
    input  logic [OPW-1:0] chal_in,
    output logic           parity,
    output logic           valid,
    output logic           busy
);

    localparam int SER = OPW / PAR;
    localparam int STW = (SER > 1) ? $clog2(SER) : 1;

    eng_state_e     st_q, st_d;
    logic [OPW-1:0] key_q, chal_q;
    logic [STW-1:0] step_q;
    logic           acc_q;
    logic [PAR-1:0] grp;
    logic           gbit;
    logic           last;

    // AND stage on the group selected by the serial step
    assign grp  = key_q[step_q*PAR +: PAR] & chal_q[step_q*PAR +: PAR];
    assign last = (step_q == STW'(SER - 1));
    assign busy = (st_q == ENG_FOLD);

    ipar_xor_tree #(.N(PAR)) u_tree (
        .bits (grp),
        .par  (gbit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ENG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENG_IDLE: if (start) st_d = ENG_FOLD;
            ENG_FOLD: if (last)  st_d = ENG_IDLE;
            default:             st_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            chal_q <= '0;
            step_q <= '0;
            acc_q  <= 1'b0;
            parity <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            unique case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        key_q  <= key_in;
                        chal_q <= chal_in;
                        step_q <= '0;
                        acc_q  <= 1'b0;
                    end
                end
                ENG_FOLD: begin
                    acc_q  <= acc_q ^ gbit;
                    step_q <= step_q + 1'b1;
                    if (last) begin
                        parity <= acc_q ^ gbit;
                        valid  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ipar_engine.sv
module ipar_engine
    import ipar_pkg::*;
#(
    parameter int OPW  = 512,
    parameter int LANE = 8,
    parameter int PAR  = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stream_en,
    input  logic [LANE-1:0] key_byte,
    input  logic [LANE-1:0] chal_byte,
    input  logic            gate_n,
    output logic            parity,
    output logic            valid
);

    localparam int BEATS = OPW / LANE;
    localparam int CNTW  = $clog2(BEATS + 1);

    col_state_e      col_q, col_d;
    logic [CNTW-1:0] beat_cnt;
    logic            shift;
    logic            xfer;
    logic            full;
    logic            busy;
    logic [OPW-1:0]  key_sr, chal_sr;

    assign full  = (col_q == COL_FULL);
    assign shift = (col_q == COL_GATHER) && stream_en;
    assign xfer  = full && !gate_n && !busy;

    ipar_deser #(.W(OPW), .LANE(LANE)) u_key_deser (
        .clk   (clk),
        .rst   (rst),
        .shift (shift),
        .din   (key_byte),
        .q     (key_sr)
    );

    ipar_deser #(.W(OPW), .LANE(LANE)) u_chal_deser (
        .clk   (clk),
        .rst   (rst),
        .shift (shift),
        .din   (chal_byte),
        .q     (chal_sr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= COL_GATHER;
        end else begin
            col_q <= col_d;
        end
    end

    always_comb begin
        col_d = col_q;
        unique case (col_q)
            COL_GATHER: if (shift && beat_cnt == CNTW'(BEATS - 1)) col_d = COL_FULL;
            COL_FULL:   if (xfer) col_d = COL_GATHER;
            default:    col_d = COL_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt <= '0;
        end else if (xfer) begin
            beat_cnt <= '0;
        end else if (shift) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    ipar_fold #(.OPW(OPW), .PAR(PAR)) u_fold (
        .clk     (clk),
        .rst     (rst),
        .start   (xfer),
        .key_in  (key_sr),
        .chal_in (chal_sr),
        .parity  (parity),
        .valid   (valid),
        .busy    (busy)
    );

endmodule

// File: rtl/ipar_engine_chk.sv
module ipar_engine_chk #(
    parameter int OPW  = 512,
    parameter int CNTW = 7,
    parameter int BEATS = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            valid,
    input logic            parity,
    input logic            busy,
    input logic            xfer,
    input logic            full,
    input logic            stream_en,
    input logic [CNTW-1:0] beat_cnt,
    input logic [OPW-1:0]  key_sr,
    input logic [OPW-1:0]  chal_sr
);

    // R1: a reset edge leaves valid low
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !valid);

    // R2: the beat count never passes one full set
    p_beat_bound_r2: assert property (@(posedge clk) disable iff (rst)
        beat_cnt <= CNTW'(BEATS));

    // R3: a complete set is frozen against further beats
    p_full_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (full && stream_en && !xfer) |=> ($stable(key_sr) && $stable(chal_sr)));

    // R4: a transfer restarts collection empty
    p_xfer_restart_r4: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (beat_cnt == '0 && !full));

    // R6: valid is a single-cycle pulse that ends a fold
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    p_valid_ends_fold_r6: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($past(busy) && !busy));

    // R7: parity holds between pulses
    p_parity_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(parity));

endmodule

bind ipar_engine ipar_engine_chk #(
    .OPW   (OPW),
    .CNTW  (CNTW),
    .BEATS (BEATS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid     (valid),
    .parity    (parity),
    .busy      (busy),
    .xfer      (xfer),
    .full      (full),
    .stream_en (stream_en),
    .beat_cnt  (beat_cnt),
    .key_sr    (key_sr),
    .chal_sr   (chal_sr)
);

// File: tb/test_ipar_engine.sv
module test_ipar_engine;

    localparam int OPW   = 512;
    localparam int LANE  = 8;
    localparam int BEATS = OPW / LANE;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            stream_en = 1'b0;
    logic [LANE-1:0] key_byte = '0;
    logic [LANE-1:0] chal_byte = '0;
    logic            gate_n = 1'b1;
    logic            parity;
    logic            valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit exp_bit[$];
    int exp_cyc[$];
    logic last_par = 1'b0;
    logic last_vld = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ipar_engine #(.OPW(OPW), .LANE(LANE), .PAR(64)) i_ipar_engine (
        .clk       (clk),
        .rst       (rst),
        .stream_en (stream_en),
        .key_byte  (key_byte),
        .chal_byte (chal_byte),
        .gate_n    (gate_n),
        .parity    (parity),
        .valid     (valid)
    );

    function automatic bit ref_ip(input logic [OPW-1:0] k, input logic [OPW-1:0] c);
        return ^(k & c);
    endfunction

    function automatic logic [OPW-1:0] rnd_word();
        logic [OPW-1:0] v;
        for (int w = 0; w < OPW / 32; w++) v[w*32 +: 32] = $random;
        return v;
    endfunction

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on each valid pulse (R5, R6, R7, R8)
    always @(negedge clk) begin
        if (rst) begin
            last_par = parity;
            last_vld = 1'b0;
        end else begin
            if (valid) begin
                check("R6 no back-to-back valid", last_vld, 1'b0);
                if (exp_bit.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4 unexpected result actual=%0b expected=none", parity);
                end else begin
                    bit eb; int ec;
                    eb = exp_bit.pop_front();
                    ec = exp_cyc.pop_front();
                    check("R5 R8 parity value", parity, eb);
                    checks++;
                    if (cyc != ec) begin
                        errors++;
                        $display("FAIL R6 result cycle actual=%0d expected=%0d", cyc, ec);
                    end
                end
            end else if (parity !== last_par) begin
                checks++; errors++;
                $display("FAIL R7 parity changed without valid actual=%0b expected=%0b", parity, last_par);
            end
            last_par = parity;
            last_vld = valid;
        end
    end

    task automatic beats(input logic [OPW-1:0] k, input logic [OPW-1:0] c,
                         input int from, input int upto);
        for (int b = from; b < upto; b++) begin
            stream_en = 1'b1;
            key_byte  = k[OPW-1-b*LANE -: LANE];
            chal_byte = c[OPW-1-b*LANE -: LANE];
            @(negedge clk);
        end
        stream_en = 1'b0;
    endtask

    task automatic gate(input bit expect_res, input bit eb);
        stream_en = 1'b0;
        gate_n = 1'b0;
        if (expect_res) begin
            exp_bit.push_back(eb);
            exp_cyc.push_back(cyc + 9);
        end
        @(negedge clk);
        gate_n = 1'b1;
    endtask

    task automatic send(input logic [OPW-1:0] k, input logic [OPW-1:0] c);
        beats(k, c, 0, BEATS);
        gate(1'b1, ref_ip(k, c));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [OPW-1:0] ka, ca, kb, cb;
        idle(3);
        check("R1 valid after reset", valid, 1'b0);
        check("R1 parity after reset", parity, 1'b0);
        rst = 1'b0;
        idle(2);

        // R1: gate straight after reset yields nothing
        gate(1'b0, 1'b0);
        idle(12);

        // R5 patterns
        send('0, '0);                                 idle(10);
        send({OPW{1'b1}}, {OPW{1'b1}});               idle(10);
        send({OPW{1'b1}}, OPW'(1));                   idle(10);
        send({1'b1, {(OPW-1){1'b0}}}, {OPW{1'b1}});   idle(10);

        // R2: premature gate ignored, collection resumes
        ka = rnd_word(); ca = rnd_word();
        ca[0] = 1'b1; ka[0] = ~^(ka[OPW-1:1] & ca[OPW-1:1]);
        beats(ka, ca, 0, 20);
        gate(1'b0, 1'b0);
        idle(12);
        beats(ka, ca, 20, BEATS);
        gate(1'b1, ref_ip(ka, ca));
        idle(10);

        // R3: extra beats after a full set are ignored
        kb = rnd_word(); cb = rnd_word();
        beats(kb, cb, 0, BEATS);
        beats(~kb, {OPW{1'b1}}, 0, 6);
        gate(1'b1, ref_ip(kb, cb));
        idle(10);

        // R4 R8: back-to-back queries overlapping the fold
        for (int n = 0; n < 6; n++) begin
            ka = rnd_word(); ca = rnd_word();
            send(ka, ca);
        end
        idle(12);

        // R1: reset mid-fill discards the partial set
        beats(ka, ca, 0, 30);
        rst = 1'b1;
        idle(2);
        check("R1 valid after mid reset", valid, 1'b0);
        check("R1 parity after mid reset", parity, 1'b0);
        rst = 1'b0;
        idle(1);
        beats(ka, ca, 30, 40);
        gate(1'b0, 1'b0);
        idle(12);
        check("R1 no result from partial set", valid, 1'b0);
        send(ka, ca);
        idle(12);

        checks++;
        if (exp_bit.size() != 0) begin
            errors++;
            $display("FAIL R8 results missing actual=%0d expected=0", exp_bit.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule